// File: doc/BRIEF.md
# Mirrored RAM and Banked Address Decoder

This block sits behind a 16-bit processor address bus and steers each access to one of three targets. The lowest 8 KB of the map reach a 2 KB work RAM, which repeats four times across that range. The middle range, from 0x2000 up to 0x7FFF, belongs to an external I/O and peripheral port. The top half of the map is served from banked storage. The map is cut into eight 8 KB windows, and a small table names the storage bank behind each window.

Reads from the banked half return the bank byte one cycle later. In that same cycle a side-band pulse tells an external mapper which address was read and which byte came back. The processor can flag an access as zero-page indexed. Such an access always lands in RAM, at a byte address formed by adding an 8-bit index to the low address byte, with wrap-around inside the first 256 bytes. A separate configuration port rewrites the bank table, which comes out of reset as an identity map. The bank storage is a read-only array. Bank b, offset o holds the byte {b[2:0], o[4:0]}, and only the low five address bits select the offset.

Top module: `memdec_top`

## Requirements
- R1: After reset, cpu_rvalid, io_rd, io_wr and map_notify are low, and window s (s = cpu_addr[15:13]) selects bank s.
- R2: A non-zero-page access below 0x2000 uses only cpu_addr[10:0], so 0x0123, 0x0923 and 0x1923 hold the same byte.
- R3: A RAM read raises cpu_rvalid with the stored byte on cpu_rdata for exactly the one cycle after the request edge.
- R4: A read in 0x2000..0x7FFF raises io_rd for one cycle after the request edge, with io_addr equal to cpu_addr. The byte on io_rdata at the first edge where io_rvalid is high is then returned on cpu_rdata with cpu_rvalid for one cycle. The processor issues no new access while this read is pending.
- R5: A read at 0x8000 or above returns, one cycle later, the byte {bank[2:0], cpu_addr[4:0]}, where bank is the table entry for window cpu_addr[15:13].
- R6: Every banked read pulses map_notify for one cycle, in the same cycle as cpu_rvalid, with map_addr equal to the read address and map_data equal to cpu_rdata. No other access pulses it.
- R7: Writes below 0x2000 update RAM and do not pulse io_wr. Every other write pulses io_wr for one cycle with io_addr and io_wdata, and leaves RAM unchanged.
- R8: With cpu_zp high, reads and writes go to RAM byte (cpu_addr[7:0] + cpu_idx) mod 256, whatever the upper address bits are. They never pulse io_rd, io_wr or map_notify.
- R9: With cfg_we high, the window cfg_slot is remapped to bank cfg_bank. A read in the same cycle still sees the old entry, and reads from the next cycle on see the new one.
- R10: io_rvalid while no I/O read is pending does not raise cpu_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rd | input | 1 | Read request, one cycle |
| cpu_wr | input | 1 | Write request, one cycle |
| cpu_zp | input | 1 | Access is zero-page indexed |
| cpu_idx | input | 8 | Index added to the low address byte for zero-page accesses |
| cpu_rdata | output | 8 | Returned read byte |
| cpu_rvalid | output | 1 | cpu_rdata is valid this cycle |
| cfg_we | input | 1 | Bank table write strobe |
| cfg_slot | input | 3 | Window to remap |
| cfg_bank | input | 3 | Bank number for that window |
| io_addr | output | 16 | External port address |
| io_wdata | output | 8 | External port write byte |
| io_rd | output | 1 | External read request pulse |
| io_wr | output | 1 | External write pulse |
| io_rdata | input | 8 | External read byte |
| io_rvalid | input | 1 | External read byte is valid |
| map_notify | output | 1 | Banked read notification pulse |
| map_addr | output | 16 | Address of the banked read |
| map_data | output | 8 | Byte returned by the banked read |

## Verification
The checker assumes that read and write requests never overlap an outstanding external read, and that io_rvalid answers such a read at most once. It follows that pending state from io_rd and io_rvalid alone. Every bench task waits for its external read to finish before it issues the next access, and it drives io_rvalid for a single cycle only. The one stray io_rvalid is driven on purpose while no external read is pending.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

    localparam int unsigned BUS_ADDR_W = 16;
    localparam int unsigned BUS_DATA_W = 8;

    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_BANK = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        SRC_RAM  = 2'd0,
        SRC_IO   = 2'd1,
        SRC_BANK = 2'd2
    } src_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_IOWAIT = 1'b1
    } state_e;

endpackage

// File: rtl/memdec_decode.sv
module memdec_decode
    import memdec_pkg::*;
#(
    parameter int unsigned ADDR_W    = BUS_ADDR_W,
    parameter int unsigned ZP_W      = 8,
    parameter int unsigned RAM_AW    = 11,
    parameter int unsigned RAM_TOP   = 16'h2000,
    parameter int unsigned BANK_BASE = 16'h8000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              zp,
    input  logic [ZP_W-1:0]   idx,
    output region_e           region,
    output logic [RAM_AW-1:0] ram_idx
);

    localparam logic [ADDR_W-1:0] RAM_TOP_A   = ADDR_W'(RAM_TOP);
    localparam logic [ADDR_W-1:0] BANK_BASE_A = ADDR_W'(BANK_BASE);

    logic [ZP_W-1:0]   zp_sum;
    logic [ADDR_W-1:0] eff;

    always_comb begin
        zp_sum = addr[ZP_W-1:0] + idx;
        eff    = zp ? ADDR_W'(zp_sum) : addr;
        if (eff < RAM_TOP_A) begin
            region = RGN_RAM;
        end else if (eff >= BANK_BASE_A) begin
            region = RGN_BANK;
        end else begin
            region = RGN_IO;
        end
        ram_idx = eff[RAM_AW-1:0];
    end

endmodule

// File: rtl/memdec_ram.sv
module memdec_ram
    import memdec_pkg::*;
#(
    parameter int unsigned DATA_W = BUS_DATA_W,
    parameter int unsigned RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [RAM_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 2 ** RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/memdec_banks.sv
module memdec_banks
    import memdec_pkg::*;
#(
    parameter int unsigned DATA_W      = BUS_DATA_W,
    parameter int unsigned SLOT_W      = 3,
    parameter int unsigned NUM_BANKS   = 8,
    parameter int unsigned STORE_OFS_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [SLOT_W-1:0]            cfg_slot,
    input  logic [$clog2(NUM_BANKS)-1:0] cfg_bank,
    input  logic                         re,
    input  logic [SLOT_W-1:0]            slot,
    input  logic [STORE_OFS_W-1:0]       ofs,
    output logic [DATA_W-1:0]            rdata
);

    localparam int unsigned BANK_W      = $clog2(NUM_BANKS);
    localparam int unsigned NUM_SLOTS   = 2 ** SLOT_W;
    localparam int unsigned STORE_DEPTH = 2 ** STORE_OFS_W;
    localparam int unsigned STORE_SIZE  = NUM_BANKS * STORE_DEPTH;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][BANK_W-1:0] map;
        logic [DATA_W-1:0]                rdata;
    } bank_s;

    bank_s bank_d, bank_q;
    logic [DATA_W-1:0] store [STORE_SIZE];

    // Storage pattern: byte = {bank, offset}, filled at reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < int'(NUM_BANKS); b++) begin
                for (int o = 0; o < int'(STORE_DEPTH); o++) begin
                    store[b * STORE_DEPTH + o] <= DATA_W'((b << STORE_OFS_W) | o);
                end
            end
        end
    end

    always_comb begin
        bank_d = bank_q;
        if (re) begin
            bank_d.rdata = store[{bank_q.map[slot], ofs}];
        end
        if (cfg_we) begin
            bank_d.map[cfg_slot] = cfg_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(NUM_SLOTS); s++) begin
                bank_q.map[s] <= BANK_W'(s);
            end
            bank_q.rdata <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata = bank_q.rdata;

endmodule

// File: rtl/memdec_top.sv
module memdec_top
    import memdec_pkg::*;
#(
    parameter int unsigned ADDR_W      = BUS_ADDR_W,
    parameter int unsigned DATA_W      = BUS_DATA_W,
    parameter int unsigned ZP_W        = 8,
    parameter int unsigned RAM_AW      = 11,
    parameter int unsigned SLOT_W      = 3,
    parameter int unsigned NUM_BANKS   = 8,
    parameter int unsigned STORE_OFS_W = 5,
    parameter int unsigned RAM_TOP     = 16'h2000,
    parameter int unsigned BANK_BASE   = 16'h8000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    input  logic                         cpu_rd,
    input  logic                         cpu_wr,
    input  logic                         cpu_zp,
    input  logic [ZP_W-1:0]              cpu_idx,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         cpu_rvalid,
    input  logic                         cfg_we,
    input  logic [SLOT_W-1:0]            cfg_slot,
    input  logic [$clog2(NUM_BANKS)-1:0] cfg_bank,
    output logic [ADDR_W-1:0]            io_addr,
    output logic [DATA_W-1:0]            io_wdata,
    output logic                         io_rd,
    output logic                         io_wr,
    input  logic [DATA_W-1:0]            io_rdata,
    input  logic                         io_rvalid,
    output logic                         map_notify,
    output logic [ADDR_W-1:0]            map_addr,
    output logic [DATA_W-1:0]            map_data
);

    localparam int unsigned SLOT_LO = ADDR_W - SLOT_W;

    typedef struct packed {
        state_e            st;
        logic              rvalid;
        src_e              src;
        logic              notify;
        logic [ADDR_W-1:0] map_addr;
        logic              io_rd;
        logic              io_wr;
        logic [ADDR_W-1:0] io_addr;
        logic [DATA_W-1:0] io_wdata;
        logic [DATA_W-1:0] io_data;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    region_e           rgn;
    logic [RAM_AW-1:0] ram_idx;
    logic              idle;
    logic              ram_we, ram_re, bank_re;
    logic [DATA_W-1:0] ram_rdata, bank_rdata;

    memdec_decode #(
        .ADDR_W    (ADDR_W),
        .ZP_W      (ZP_W),
        .RAM_AW    (RAM_AW),
        .RAM_TOP   (RAM_TOP),
        .BANK_BASE (BANK_BASE)
    ) u_decode (
        .addr    (cpu_addr),
        .zp      (cpu_zp),
        .idx     (cpu_idx),
        .region  (rgn),
        .ram_idx (ram_idx)
    );

    assign idle    = (ctl_q.st == ST_IDLE);
    assign ram_re  = idle && cpu_rd && (rgn == RGN_RAM);
    assign ram_we  = idle && !cpu_rd && cpu_wr && (rgn == RGN_RAM);
    assign bank_re = idle && cpu_rd && (rgn == RGN_BANK);

    memdec_ram #(
        .DATA_W (DATA_W),
        .RAM_AW (RAM_AW)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_idx),
        .wdata (cpu_wdata),
        .rdata (ram_rdata)
    );

    memdec_banks #(
        .DATA_W      (DATA_W),
        .SLOT_W      (SLOT_W),
        .NUM_BANKS   (NUM_BANKS),
        .STORE_OFS_W (STORE_OFS_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_slot (cfg_slot),
        .cfg_bank (cfg_bank),
        .re       (bank_re),
        .slot     (cpu_addr[ADDR_W-1:SLOT_LO]),
        .ofs      (cpu_addr[STORE_OFS_W-1:0]),
        .rdata    (bank_rdata)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        ctl_d.notify = 1'b0;
        ctl_d.io_rd  = 1'b0;
        ctl_d.io_wr  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_rd) begin
                    unique case (rgn)
                        RGN_RAM: begin
                            ctl_d.rvalid = 1'b1;
                            ctl_d.src    = SRC_RAM;
                        end
                        RGN_BANK: begin
                            ctl_d.rvalid   = 1'b1;
                            ctl_d.src      = SRC_BANK;
                            ctl_d.notify   = 1'b1;
                            ctl_d.map_addr = cpu_addr;
                        end
                        default: begin
                            ctl_d.io_rd   = 1'b1;
                            ctl_d.io_addr = cpu_addr;
                            ctl_d.st      = ST_IOWAIT;
                        end
                    endcase
                end else if (cpu_wr && (rgn != RGN_RAM)) begin
                    ctl_d.io_wr    = 1'b1;
                    ctl_d.io_addr  = cpu_addr;
                    ctl_d.io_wdata = cpu_wdata;
                end
            end
            ST_IOWAIT: begin
                if (io_rvalid) begin
                    ctl_d.io_data = io_rdata;
                    ctl_d.rvalid  = 1'b1;
                    ctl_d.src     = SRC_IO;
                    ctl_d.st      = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, src: SRC_RAM, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        unique case (ctl_q.src)
            SRC_RAM:  cpu_rdata = ram_rdata;
            SRC_BANK: cpu_rdata = bank_rdata;
            default:  cpu_rdata = ctl_q.io_data;
        endcase
    end

    assign cpu_rvalid = ctl_q.rvalid;
    assign io_addr    = ctl_q.io_addr;
    assign io_wdata   = ctl_q.io_wdata;
    assign io_rd      = ctl_q.io_rd;
    assign io_wr      = ctl_q.io_wr;
    assign map_notify = ctl_q.notify;
    assign map_addr   = ctl_q.map_addr;
    assign map_data   = bank_rdata;

endmodule

// File: rtl/memdec_checker.sv
module memdec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        cpu_zp,
    input logic [7:0]  cpu_rdata,
    input logic        cpu_rvalid,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic        io_rd,
    input logic        io_wr,
    input logic        io_rvalid,
    input logic        map_notify,
    input logic [15:0] map_addr,
    input logic [7:0]  map_data
);

    logic pend_q;
    logic waiting;

    assign waiting = io_rd || pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= waiting && !io_rvalid;
        end
    end

    // R4: the processor keeps quiet while an external read is outstanding
    assert_no_req_in_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !(cpu_rd || cpu_wr));

    assert_io_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd);

    assert_io_rd_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_zp && !waiting && cpu_addr >= 16'h2000 && cpu_addr < 16'h8000)
        |=> (io_rd && io_addr == $past(cpu_addr)));

    assert_ram_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !waiting && (cpu_zp || cpu_addr < 16'h2000)) |=> cpu_rvalid);

    assert_bank_notify_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_zp && !waiting && cpu_addr[15])
        |=> (map_notify && map_addr == $past(cpu_addr)));

    assert_notify_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        map_notify |-> (cpu_rvalid && map_data == cpu_rdata));

    assert_ext_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && !cpu_zp && !waiting && cpu_addr >= 16'h2000)
        |=> (io_wr && io_addr == $past(cpu_addr) && io_wdata == $past(cpu_wdata)));

    assert_ram_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && (cpu_zp || cpu_addr < 16'h2000)) |=> !io_wr);

    assert_zp_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_zp && (cpu_rd || cpu_wr)) |=> (!io_rd && !io_wr && !map_notify));

    assert_stray_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && !waiting && !cpu_rd) |=> !cpu_rvalid);

    assert_strobes_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr, map_notify}));

endmodule

bind memdec_top memdec_checker u_memdec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_zp     (cpu_zp),
    .cpu_rdata  (cpu_rdata),
    .cpu_rvalid (cpu_rvalid),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_rvalid  (io_rvalid),
    .map_notify (map_notify),
    .map_addr   (map_addr),
    .map_data   (map_data)
);

// File: tb/memdec_top_test.sv
module memdec_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_zp = 1'b0;
    logic [7:0]  cpu_idx = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic [2:0]  cfg_bank = '0;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic        io_rd;
    logic        io_wr;
    logic [7:0]  io_rdata = '0;
    logic        io_rvalid = 1'b0;
    logic        map_notify;
    logic [15:0] map_addr;
    logic [7:0]  map_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memdec_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_zp     (cpu_zp),
        .cpu_idx    (cpu_idx),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .cfg_we     (cfg_we),
        .cfg_slot   (cfg_slot),
        .cfg_bank   (cfg_bank),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_rdata   (io_rdata),
        .io_rvalid  (io_rvalid),
        .map_notify (map_notify),
        .map_addr   (map_addr),
        .map_data   (map_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bank_byte(input logic [2:0] bank, input logic [15:0] a);
        return {bank, a[4:0]};
    endfunction

    // Drive one request for a cycle; returns at the falling edge after the
    // capturing edge, with all request inputs released.
    task automatic issue(input bit rd, input bit wr, input logic [15:0] a,
                         input logic [7:0] wd, input bit zp, input logic [7:0] ix);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        cpu_zp = zp; cpu_idx = ix;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_zp = 1'b0; cpu_idx = '0;
    endtask

    task automatic t_reset;
        chk("R1", "rvalid after reset", 32'(cpu_rvalid), 32'd0);
        chk("R1", "io_rd after reset", 32'(io_rd), 32'd0);
        chk("R1", "io_wr after reset", 32'(io_wr), 32'd0);
        chk("R1", "notify after reset", 32'(map_notify), 32'd0);
    endtask

    task automatic t_ram_mirror;
        issue(1'b0, 1'b1, 16'h0123, 8'h3C, 1'b0, 8'h00);
        chk("R7", "no io_wr for RAM write", 32'(io_wr), 32'd0);
        issue(1'b1, 1'b0, 16'h1923, 8'h00, 1'b0, 8'h00);
        chk("R3", "RAM read valid", 32'(cpu_rvalid), 32'd1);
        chk("R2", "mirror 0x1923", 32'(cpu_rdata), 32'h3C);
        chk("R6", "no notify on RAM read", 32'(map_notify), 32'd0);
        @(negedge clk);
        chk("R3", "valid lasts one cycle", 32'(cpu_rvalid), 32'd0);
        issue(1'b0, 1'b1, 16'h1FFF, 8'hA7, 1'b0, 8'h00);
        issue(1'b1, 1'b0, 16'h07FF, 8'h00, 1'b0, 8'h00);
        chk("R2", "mirror top byte", 32'(cpu_rdata), 32'hA7);
    endtask

    task automatic t_io_read;
        issue(1'b1, 1'b0, 16'h4567, 8'h00, 1'b0, 8'h00);
        chk("R4", "io_rd raised", 32'(io_rd), 32'd1);
        chk("R4", "io_addr", 32'(io_addr), 32'h4567);
        chk("R4", "no early valid", 32'(cpu_rvalid), 32'd0);
        io_rvalid = 1'b1; io_rdata = 8'h9E;
        @(negedge clk);
        io_rvalid = 1'b0; io_rdata = 8'h00;
        chk("R4", "io_rd one cycle", 32'(io_rd), 32'd0);
        chk("R4", "io result valid", 32'(cpu_rvalid), 32'd1);
        chk("R4", "io result data", 32'(cpu_rdata), 32'h9E);
        chk("R6", "no notify on io read", 32'(map_notify), 32'd0);
        // delayed answer
        issue(1'b1, 1'b0, 16'h2001, 8'h00, 1'b0, 8'h00);
        chk("R4", "io_rd lower edge", 32'(io_addr), 32'h2001);
        @(negedge clk);
        chk("R4", "waiting, no valid", 32'(cpu_rvalid), 32'd0);
        @(negedge clk);
        io_rvalid = 1'b1; io_rdata = 8'h31;
        @(negedge clk);
        io_rvalid = 1'b0;
        chk("R4", "late io data", 32'(cpu_rdata), 32'h31);
        chk("R4", "late io valid", 32'(cpu_rvalid), 32'd1);
    endtask

    task automatic t_bank_identity;
        for (int s = 4; s < 8; s++) begin
            logic [15:0] a;
            a = 16'(s << 13) | 16'h0125 + 16'(s);
            issue(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00);
            chk("R5", "bank read valid", 32'(cpu_rvalid), 32'd1);
            chk("R1", "identity bank data", 32'(cpu_rdata), 32'(bank_byte(3'(s), a)));
            chk("R6", "notify pulse", 32'(map_notify), 32'd1);
            chk("R6", "notify addr", 32'(map_addr), 32'(a));
            chk("R6", "notify data", 32'(map_data), 32'(bank_byte(3'(s), a)));
        end
        @(negedge clk);
        chk("R6", "notify one cycle", 32'(map_notify), 32'd0);
    endtask

    task automatic t_cfg;
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 3'd5; cfg_bank = 3'd2;
        @(negedge clk);
        cfg_we = 1'b0;
        issue(1'b1, 1'b0, 16'hA005, 8'h00, 1'b0, 8'h00);
        chk("R9", "slot 5 to bank 2", 32'(cpu_rdata), 32'h45);
        // remap in the same cycle as a read of that window
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 3'd6; cfg_bank = 3'd1;
        cpu_rd = 1'b1; cpu_addr = 16'hC003;
        @(negedge clk);
        cfg_we = 1'b0; cpu_rd = 1'b0;
        chk("R9", "same-cycle read sees old bank", 32'(cpu_rdata), 32'hC3);
        issue(1'b1, 1'b0, 16'hDFE3, 8'h00, 1'b0, 8'h00);
        chk("R9", "later read sees new bank", 32'(cpu_rdata), 32'h23);
        chk("R5", "offset from low five bits", 32'(map_data), 32'h23);
    endtask

    task automatic t_ext_writes;
        issue(1'b0, 1'b1, 16'h2123, 8'h77, 1'b0, 8'h00);
        chk("R7", "io_wr pulse", 32'(io_wr), 32'd1);
        chk("R7", "io_wr addr", 32'(io_addr), 32'h2123);
        chk("R7", "io_wr data", 32'(io_wdata), 32'h77);
        @(negedge clk);
        chk("R7", "io_wr one cycle", 32'(io_wr), 32'd0);
        issue(1'b0, 1'b1, 16'h9123, 8'h66, 1'b0, 8'h00);
        chk("R7", "bank-region write goes out", 32'(io_addr), 32'h9123);
        chk("R7", "bank-region write data", 32'(io_wdata), 32'h66);
        issue(1'b1, 1'b0, 16'h0123, 8'h00, 1'b0, 8'h00);
        chk("R7", "RAM untouched by external writes", 32'(cpu_rdata), 32'h3C);
    endtask

    task automatic t_zero_page;
        issue(1'b0, 1'b1, 16'h00F0, 8'h5A, 1'b1, 8'h20);
        chk("R8", "zp write stays local", 32'(io_wr), 32'd0);
        issue(1'b1, 1'b0, 16'h0810, 8'h00, 1'b0, 8'h00);
        chk("R8", "zp write wrapped to 0x10", 32'(cpu_rdata), 32'h5A);
        issue(1'b1, 1'b0, 16'hFFF0, 8'h00, 1'b1, 8'h20);
        chk("R8", "zp read ignores upper bits", 32'(cpu_rdata), 32'h5A);
        chk("R8", "zp read valid", 32'(cpu_rvalid), 32'd1);
        chk("R8", "zp read no notify", 32'(map_notify), 32'd0);
        chk("R8", "zp read no io_rd", 32'(io_rd), 32'd0);
        issue(1'b1, 1'b0, 16'h4100, 8'h00, 1'b1, 8'h10);
        chk("R8", "zp in io range stays RAM", 32'(cpu_rdata), 32'h5A);
    endtask

    task automatic t_stray_valid;
        @(negedge clk);
        io_rvalid = 1'b1; io_rdata = 8'hEE;
        @(negedge clk);
        io_rvalid = 1'b0;
        chk("R10", "stray io_rvalid ignored", 32'(cpu_rvalid), 32'd0);
        chk("R10", "no io_rd from stray", 32'(io_rd), 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ram_mirror();
        t_io_read();
        t_bank_identity();
        t_cfg();
        t_ext_writes();
        t_zero_page();
        t_stray_valid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule